// File: doc/BRIEF.md
# Fractional Clock-Enable Rate Generator

This block turns a free-running clock into a stream of one-cycle enable strobes whose average rate is the clock rate divided by (1 + MULT/256). It never creates a new clock. Instead it drops selected input cycles from an otherwise continuous strobe train. A downstream integer divider consumes the strobes to form the final bit-rate tick.

The drops are placed by a remainder accumulator. Each emitted strobe adds MULT to the accumulator. When the sum carries past 256, the cycle after that strobe is dropped and the carry is discarded. This spreads the dropped cycles as evenly as an integer sequence allows.

A MULT of zero disables division, so a strobe appears on every cycle. Deasserting the run input, or applying reset, clears all state and holds the strobe low.

Top module: `frac_rate_gen`

## Requirements
- R1: While `rst` is high, `rateStrobe` is low, and the accumulator and any pending drop are cleared.
- R2: With `mult` = 0 and `run` high, `rateStrobe` is high on every cycle.
- R3: Consider a start from reset or idle with a constant `mult` = M. In the first 256 + M cycles that follow, exactly 256 strobes are emitted and exactly M cycles are dropped.
- R4: The distance between two consecutive strobes is always one or two cycles while `run` stays high. Two adjacent cycles are never both dropped.
- R5: A cycle is dropped exactly when the preceding strobe was the k-th since start and floor(k·M/256) > floor((k−1)·M/256). For M = 128 the pattern is strobe, strobe, drop, repeating. The accumulator only changes on cycles that emit.
- R6: When `run` is sampled low, `rateStrobe` is low from the next cycle on, and the accumulator is cleared. A later restart reproduces the pattern from zero.
- R7: A change of `mult` is used at the next accumulator update. The remainder already held is kept, not cleared.
- R8: After `run` is first sampled high, with reset released, the first strobe appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables strobe generation; low clears state |
| mult | input | FRAC_BITS (8) | Fractional increment M; the divide ratio is 1 + M/256 |
| rateStrobe | output | 1 | One-cycle enable strobe on the input clock |

## Verification
The assertions assume that `rst` is asserted from time zero for at least two cycles. This makes the history checks that look back two cycles start from cleared state. They also assume that `mult` and `run` change only between clock edges. The bench drives every input one time step after the rising edge and applies reset before each scenario, so both conditions hold. The check for the remainder being kept is the only one that changes `mult` while running. It does so just after an emitting edge, so the new value meets exactly one accumulator update before it is observed.

// File: rtl/frg_pkg.sv
package frg_pkg;

  // Strobes from the sequencing control to the remainder datapath.
  typedef struct packed {
    logic clear;    // zero the remainder
    logic advance;  // this cycle emits: add the increment to the remainder
  } frgCtrl_t;

endpackage

// File: rtl/frg_datapath.sv
module frg_datapath
  import frg_pkg::*;
#(
  parameter int FRAC_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  frgCtrl_t             ctrl,
  input  logic [FRAC_BITS-1:0] incr,
  output logic                 carry,
  output logic [FRAC_BITS-1:0] remainder
);

  localparam int SUM_W = FRAC_BITS + 1;

  logic [FRAC_BITS-1:0] accQ;
  logic [SUM_W-1:0]     sumNext;

  // The sum is one bit wider than the remainder; its top bit is the overflow.
  always_comb begin
    sumNext = {1'b0, accQ} + {1'b0, incr};
    carry   = sumNext[FRAC_BITS];
  end

  // The overflow is dropped by keeping only the low bits.
  always_ff @(posedge clk) begin
    if (rst || ctrl.clear) begin
      accQ <= '0;
    end else if (ctrl.advance) begin
      accQ <= sumNext[FRAC_BITS-1:0];
    end
  end

  assign remainder = accQ;

endmodule

// File: rtl/frg_ctrl.sv
module frg_ctrl
  import frg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     carry,
  output frgCtrl_t ctrl,
  output logic     strobe
);

  logic dropPending;
  logic strobeQ;

  always_comb begin
    ctrl.clear   = !run;
    ctrl.advance = run && !dropPending;
  end

  // An emitting cycle arms a drop when the remainder overflows.
  // A dropping cycle always disarms it.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      dropPending <= 1'b0;
      strobeQ     <= 1'b0;
    end else if (dropPending) begin
      dropPending <= 1'b0;
      strobeQ     <= 1'b0;
    end else begin
      dropPending <= carry;
      strobeQ     <= 1'b1;
    end
  end

  assign strobe = strobeQ;

  // R4: a dropped cycle inside a run is always followed by a strobe.
  a_r4_no_double_drop: assert property (@(posedge clk) disable iff (rst)
    (!strobeQ && $past(run) && !$past(rst) && run) |=> strobeQ);

  // R6: a low run sampled at an edge leaves the strobe low afterwards.
  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !strobeQ);

endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen
  import frg_pkg::*;
#(
  parameter int FRAC_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [FRAC_BITS-1:0] mult,
  output logic                 rateStrobe
);

  frgCtrl_t             ctrlBus;
  logic                 carryBit;
  logic [FRAC_BITS-1:0] remainder;

  frg_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .carry  (carryBit),
    .ctrl   (ctrlBus),
    .strobe (rateStrobe)
  );

  frg_datapath #(.FRAC_BITS(FRAC_BITS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrlBus),
    .incr      (mult),
    .carry     (carryBit),
    .remainder (remainder)
  );

  // R2: a zero increment two cycles back cannot have armed a drop.
  a_r2_unity: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && ($past(mult, 2) == '0) && !$past(rst) && !$past(rst, 2))
      |-> rateStrobe);

  // R5: the remainder holds still across a dropped cycle.
  a_r5_hold_on_drop: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(rst) && !rateStrobe) |-> $stable(remainder));

endmodule

// File: tb/sim_frac_rate_gen.sv
module sim_frac_rate_gen;

  localparam time CLK_PERIOD = 10ns;
  localparam int  DEN        = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [7:0] mult = 8'd0;
  logic       rateStrobe;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  frac_rate_gen u0 (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .mult       (mult),
    .rateStrobe (rateStrobe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Hold reset with run high, then release it. The next tick is the first active edge.
  task automatic doReset(input int m);
    rst  = 1'b1;
    run  = 1'b1;
    mult = 8'(m);
    repeat (3) tick();
    check(rateStrobe == 1'b0, "R1 strobe low in reset", int'(rateStrobe), 0);
    rst = 1'b0;
  endtask

  // One full period from reset with constant M.
  task automatic runWindow(input int m);
    int cnt = 0, last = -1, maxGap = 0, mism = 0, emitted = 0, first = 0;
    bit dropNext = 0;
    bit expS;
    doReset(m);
    for (int i = 0; i < DEN + m; i++) begin
      tick();
      if (i == 0) first = int'(rateStrobe);
      expS = !dropNext;
      if (rateStrobe != expS) mism++;
      if (expS) begin
        emitted++;
        dropNext = ((emitted * m) / DEN) > (((emitted - 1) * m) / DEN);
      end else begin
        dropNext = 0;
      end
      if (rateStrobe) begin
        cnt++;
        if (last >= 0 && (i - last) > maxGap) maxGap = i - last;
        last = i;
      end
    end
    check(first == 1, "R8 first strobe one cycle after start", first, 1);
    check(cnt == DEN, "R3 strobes in 256+M window", cnt, DEN);
    check(maxGap <= 2, "R4 max strobe gap", maxGap, 2);
    check(mism == 0, "R5 drop placement mismatches", mism, 0);
    if (m == 0) check(maxGap == 1, "R2 strobe every cycle", maxGap, 1);
  endtask

  // Idle clears state: the pattern restarts from zero.
  task automatic testIdle();
    int s1, s2, s3;
    doReset(200);
    repeat (7) tick();
    run = 1'b0;
    tick();
    check(rateStrobe == 1'b0, "R6 strobe low after run low", int'(rateStrobe), 0);
    repeat (3) tick();
    check(rateStrobe == 1'b0, "R6 strobe held low while idle", int'(rateStrobe), 0);
    run = 1'b1;
    tick(); s1 = int'(rateStrobe);
    tick(); s2 = int'(rateStrobe);
    tick(); s3 = int'(rateStrobe);
    // From a cleared remainder with M=200: emit, emit (sum 400 overflows), drop.
    check(s1 == 1 && s2 == 1, "R6 restart emits twice", s1 + s2, 2);
    check(s3 == 0, "R6 restart drops third cycle", s3, 0);
  endtask

  // The remainder is kept when the increment changes.
  task automatic testMultChange();
    int s2, s3;
    doReset(100);
    tick();          // first emit, remainder becomes 100
    mult = 8'd200;   // next update: 100+200 = 300 overflows
    tick(); s2 = int'(rateStrobe);
    tick(); s3 = int'(rateStrobe);
    check(s2 == 1, "R7 emit after change", s2, 1);
    check(s3 == 0, "R7 drop from kept remainder", s3, 0);
  endtask

  // The M=128 pattern is strobe, strobe, drop.
  task automatic testHalf();
    int pat = 0;
    doReset(128);
    for (int i = 0; i < 6; i++) begin
      tick();
      pat = (pat << 1) | int'(rateStrobe);
    end
    check(pat == 6'b110110, "R5 M=128 pattern", pat, 6'b110110);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog R1..all actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    runWindow(0);
    runWindow(1);
    runWindow(128);
    runWindow(255);
    runWindow(77);
    testHalf();
    testIdle();
    testMultChange();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule